// File: doc/BRIEF.md
# Clock Synthesizer Configuration Word Loader

This block keeps the configuration word of a programmable clock synthesizer. The word has three fields: a 3-bit test selector, a 2-bit output divider code and a 9-bit feedback divider value. The outputs of the configuration latch drive these three fields directly into the synthesizer.

The word can be loaded in two ways. In the serial path, a 14-stage shift register takes one bit on each rising clock edge. A rising edge on the serial load strobe then copies the whole register into the latch. In the parallel path, a rising edge on the parallel load strobe copies the divider pins straight into the latch and clears the test selector. A parallel load also releases the observation output, so it follows the top stage of the shift chain again.

The observation output normally shows the last stage of the shift register. This lets a word that was shifted in be read back on later clocks. When a serial load enters the bypass test code, the observation output holds the latched top test bit. It keeps holding that bit until a parallel load or a reset releases it.

Top module: `cfg_word_loader`

## Requirements
- R1: A synchronous active-high reset clears the shift register and all three latched fields to zero, and releases the observation output so that it follows the shift chain.
- R2: On every clock edge outside reset, the shift register moves one place toward its top stage and takes the serial data bit into its bottom stage. While the observation output is released, it equals the bit that was shifted in 14 edges earlier.
- R3: On the first edge with the serial load strobe high after an edge with it low, the latch takes the shift register contents as they were before that edge. The bit order is as follows. The oldest bit lands in test bit 2, then test bit 1, then test bit 0, then divider code bit 1, then divider code bit 0, then feedback bits 8 down to 0. The newest bit is feedback bit 0.
- R4: The latched fields change only on a strobe rising edge. A strobe held high and continued shifting leave them unchanged.
- R5: On a rising edge of the parallel load strobe, the latch takes the feedback value and divider code pins, and the test selector becomes 000.
- R6: When both strobes rise on the same edge, the parallel load wins.
- R7: A serial load that latches test code 110 makes the observation output hold the latched test bit 2 (value 1). A later parallel load, or a serial load of any other test code, releases the output back to the top shift stage.
- R8: A parallel load does not alter the shift register contents. A word that was already shifted in still reads back in order on the observation output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sdin | input | 1 | Serial data bit |
| sload | input | 1 | Serial load strobe (acts on rising edge) |
| pload | input | 1 | Parallel load strobe (acts on rising edge) |
| pm | input | 9 | Parallel feedback divider value |
| pn | input | 2 | Parallel output divider code |
| cfg_t | output | 3 | Latched test selector |
| cfg_n | output | 2 | Latched output divider code |
| cfg_m | output | 9 | Latched feedback divider value |
| sobs | output | 1 | Serial observation output |

## Verification
A strobe rising edge that is present at clock edge k shows up on the latched fields just after edge k. The strobe needs one cycle low before it can count as a new rise. A serial bit reaches the observation output 14 edges after it was shifted in. The freeze or release of that output takes effect on the same edge as the load that causes it. The bench applies inputs 2 ns after each rising edge and compares every output 1 ns after each edge with a behavioural model. The directed checks are read after the edge that should produce their result, so each one sits at exactly the cycle on which the result is due.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;

  // Source that updates the configuration latch on a given edge.
  typedef enum logic [1:0] {
    LD_NONE     = 2'd0,
    LD_SERIAL   = 2'd1,
    LD_PARALLEL = 2'd2
  } ld_src_e;

  // Parallel load has priority over serial load on a shared edge.
  function automatic ld_src_e pick_src(input logic ser_rise, input logic par_rise);
    if (par_rise) return LD_PARALLEL;
    if (ser_rise) return LD_SERIAL;
    return LD_NONE;
  endfunction

endpackage

// File: rtl/cfgload_rise.sv
module cfgload_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/cfgload_shift.sv
module cfgload_shift #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         din,
  output logic [W-1:0] sr
);
  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[W-2:0], din};
  end

  // R2: the new bit enters the bottom stage
  p_bottom_in_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sr[0] == $past(din));

  // R2: every other stage takes its lower neighbour
  p_move_up_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sr[W-1:1] == $past(sr[W-2:0]));
endmodule

// File: rtl/cfgload_latch.sv
module cfgload_latch
  import cfgload_pkg::*;
#(
  parameter int              T_W       = 3,
  parameter int              N_W       = 2,
  parameter int              M_W       = 9,
  parameter logic [T_W-1:0]  TEST_CODE = 3'b110,
  localparam int             W         = T_W + N_W + M_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ser_rise,
  input  logic           par_rise,
  input  logic [W-1:0]   sr_word,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  output logic [T_W-1:0] cfg_t,
  output logic [N_W-1:0] cfg_n,
  output logic [M_W-1:0] cfg_m,
  output logic           obs_live
);
  ld_src_e src;
  assign src = pick_src(ser_rise, par_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_t    <= '0;
      cfg_n    <= '0;
      cfg_m    <= '0;
      obs_live <= 1'b1;
    end else begin
      case (src)
        LD_PARALLEL: begin
          cfg_t    <= '0;
          cfg_n    <= par_n;
          cfg_m    <= par_m;
          obs_live <= 1'b1;
        end
        LD_SERIAL: begin
          cfg_t    <= sr_word[W-1 -: T_W];
          cfg_n    <= sr_word[M_W +: N_W];
          cfg_m    <= sr_word[M_W-1:0];
          obs_live <= (sr_word[W-1 -: T_W] != TEST_CODE);
        end
        default: ;
      endcase
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (cfg_t == '0 && cfg_n == '0 && cfg_m == '0 && obs_live));

  p_ser_copy_r3: assert property (@(posedge clk) disable iff (rst)
    ser_rise && !par_rise |=> {cfg_t, cfg_n, cfg_m} == $past(sr_word));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !ser_rise && !par_rise |=> $stable(cfg_t) && $stable(cfg_n) && $stable(cfg_m));

  // R5 and R6: parallel data taken, test field cleared, even with a serial rise
  p_par_load_r5: assert property (@(posedge clk) disable iff (rst)
    par_rise |=> cfg_t == '0 && cfg_m == $past(par_m) && cfg_n == $past(par_n));
endmodule

// File: rtl/cfg_word_loader.sv
module cfg_word_loader #(
  parameter int              T_W       = 3,
  parameter int              N_W       = 2,
  parameter int              M_W       = 9,
  parameter logic [T_W-1:0]  TEST_CODE = 3'b110,
  localparam int             W         = T_W + N_W + M_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sdin,
  input  logic           sload,
  input  logic           pload,
  input  logic [M_W-1:0] pm,
  input  logic [N_W-1:0] pn,
  output logic [T_W-1:0] cfg_t,
  output logic [N_W-1:0] cfg_n,
  output logic [M_W-1:0] cfg_m,
  output logic           sobs
);
  logic         ser_rise;
  logic         par_rise;
  logic [W-1:0] sr;
  logic         obs_live;

  cfgload_rise u_ser_edge (.clk(clk), .rst(rst), .lvl(sload), .rise(ser_rise));
  cfgload_rise u_par_edge (.clk(clk), .rst(rst), .lvl(pload), .rise(par_rise));

  cfgload_shift #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .din(sdin), .sr(sr)
  );

  cfgload_latch #(
    .T_W(T_W), .N_W(N_W), .M_W(M_W), .TEST_CODE(TEST_CODE)
  ) u_latch (
    .clk(clk), .rst(rst),
    .ser_rise(ser_rise), .par_rise(par_rise),
    .sr_word(sr), .par_m(pm), .par_n(pn),
    .cfg_t(cfg_t), .cfg_n(cfg_n), .cfg_m(cfg_m),
    .obs_live(obs_live)
  );

  // Released: top shift stage. Held: latched top test bit.
  assign sobs = obs_live ? sr[W-1] : cfg_t[T_W-1];

  p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    ser_rise && !par_rise && sr[W-1 -: T_W] == TEST_CODE |=> sobs);

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    par_rise |=> sobs == sr[W-1]);
endmodule

// File: tb/cfg_word_loader_bench.sv
module cfg_word_loader_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sdin = 1'b0, sload = 1'b0, pload = 1'b0;
  logic [8:0] pm = '0;
  logic [1:0] pn = '0;
  logic [2:0] cfg_t;
  logic [1:0] cfg_n;
  logic [8:0] cfg_m;
  logic       sobs;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_word_loader u_cfg_word_loader (
    .clk(clk), .rst(rst), .sdin(sdin), .sload(sload), .pload(pload),
    .pm(pm), .pn(pn), .cfg_t(cfg_t), .cfg_n(cfg_n), .cfg_m(cfg_m), .sobs(sobs)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: queue of bits, oldest at the front.
  bit mq[$];
  int mt, mn, mm;
  bit live, sp, pp;

  always @(posedge clk) begin
    bit se, pe;
    if (rst) begin
      mq.delete();
      repeat (14) mq.push_back(1'b0);
      mt = 0; mn = 0; mm = 0; live = 1; sp = 0; pp = 0;
    end else begin
      se = sload && !sp;
      pe = pload && !pp;
      if (pe) begin
        mt = 0; mn = pn; mm = pm; live = 1;
      end else if (se) begin
        mt = mq[0] * 4 + mq[1] * 2 + mq[2];
        mn = mq[3] * 2 + mq[4];
        mm = 0;
        for (int i = 5; i < 14; i++) mm = mm * 2 + mq[i];
        live = (mt != 6);
      end
      mq.push_back(sdin);
      void'(mq.pop_front());
      sp = sload; pp = pload;
    end
  end

  always @(posedge clk) begin
    #1;
    if (mq.size() == 14 && !done) begin
      chk("R3/R5 cfg_t", cfg_t, mt);
      chk("R3/R5 cfg_n", cfg_n, mn);
      chk("R3/R5 cfg_m", cfg_m, mm);
      chk("R2/R7 sobs", sobs, live ? mq[0] : (mt >> 2) & 1);
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic shift_word(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) begin
      sdin = w[i];
      tick();
    end
    sdin = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [13:0] w1, w2, w3;
    w1 = 14'b101_10_110010011;
    w2 = 14'b011_01_001101101;
    w3 = 14'b110_01_000000011;

    repeat (3) tick();
    chk("R1 reset t", cfg_t, 0);
    chk("R1 reset m", cfg_m, 0);
    chk("R1 reset obs", sobs, 0);
    rst = 1'b0;

    // R3 serial load and bit order
    shift_word(w1);
    chk("R2 first bit on top", sobs, w1[13]);
    sload = 1'b1; tick();
    chk("R3 t", cfg_t, 3'b101);
    chk("R3 n", cfg_n, 2'b10);
    chk("R3 m", cfg_m, 9'b110010011);

    // R4 strobe held high while shifting
    sdin = 1'b1;
    repeat (5) tick();
    chk("R4 t held", cfg_t, 3'b101);
    chk("R4 m held", cfg_m, 9'b110010011);
    sload = 1'b0; sdin = 1'b0; tick();

    // R2/R8 readback across a parallel load; R5 parallel fields
    shift_word(w2);
    for (int k = 0; k < 14; k++) begin
      chk("R2/R8 readback", sobs, w2[13-k]);
      if (k == 0) begin pm = 9'h0F0; pn = 2'd1; pload = 1'b1; end
      tick();
      if (k == 0) begin
        pload = 1'b0;
        chk("R5 t zero", cfg_t, 0);
        chk("R5 n", cfg_n, 1);
        chk("R5 m", cfg_m, 9'h0F0);
      end
    end

    // R6 both strobes on one edge
    shift_word(w1);
    pm = 9'h155; pn = 2'd3; sload = 1'b1; pload = 1'b1; tick();
    sload = 1'b0; pload = 1'b0;
    chk("R6 t", cfg_t, 0);
    chk("R6 n", cfg_n, 3);
    chk("R6 m", cfg_m, 9'h155);
    tick();

    // R7 freeze on test code, release on parallel load
    shift_word(w3);
    sload = 1'b1; tick(); sload = 1'b0;
    chk("R7 test code latched", cfg_t, 6);
    chk("R7 frozen", sobs, 1);
    shift_word(14'd0);
    chk("R7 still frozen", sobs, 1);
    pm = 9'd0; pn = 2'd0; pload = 1'b1; tick(); pload = 1'b0;
    chk("R7 released by parallel", sobs, 0);
    shift_word(w3);
    sload = 1'b1; tick(); sload = 1'b0;
    shift_word(w1);
    sload = 1'b1; tick(); sload = 1'b0;
    chk("R7 released by other code", sobs, w1[12]);

    // R1 reset mid-run
    rst = 1'b1; tick();
    chk("R1 mid reset t", cfg_t, 0);
    chk("R1 mid reset n", cfg_n, 0);
    chk("R1 mid reset m", cfg_m, 0);
    rst = 1'b0;

    // Mixed random traffic against the model
    for (int c = 0; c < 600; c++) begin
      sdin  = $urandom_range(0, 1);
      sload = ($urandom_range(0, 9) == 0);
      pload = ($urandom_range(0, 14) == 0);
      pm    = 9'($urandom);
      pn    = 2'($urandom);
      tick();
    end
    sload = 1'b0; pload = 1'b0;
    tick();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule